// File: doc/BRIEF.md
# Integer Execute ALU with Immediate Operand Extension

This block is the integer arithmetic and logic unit of the execute stage in a 32-bit load/store RISC pipeline. It has no clock and no state. The first operand always comes from a register. The second operand comes either from a register or from the 16-bit immediate field of the instruction, extended to full width.

The opcode controls the extension. Logic operations always zero-fill the immediate. Arithmetic and compare operations sign-fill it when the opcode is a signed variant and zero-fill it when the opcode is an unsigned variant.

Signed add and subtract raise an overflow trap strobe when the two's-complement result does not fit. When that happens, the write enable for the destination register is pulled low. Unsigned variants wrap without any indication. Comparisons return the integer 1 or 0 in the result, because the core has no condition-flag register.

Top module: `rv_alu`

## Requirements
- R1: Opcodes ADD (4'b0000), ADDU (4'b0001), SUB (4'b0010) and SUBU (4'b0011) drive `result` with the operand sum or difference, wrapped modulo 2^32.
- R2: ADD and SUB raise `ovf_trap` exactly when the true signed result lies outside the 32-bit two's-complement range. This includes 0x7FFFFFFF+1 and 0x80000000-1.
- R3: ADDU and SUBU never raise `ovf_trap`.
- R4: `wr_en` is low whenever `ovf_trap` is high. For every defined opcode that does not trap, `wr_en` is high.
- R5: With `use_imm`=1, the logic opcodes zero-extend `imm_raw` to 32 bits. The logic opcodes are AND (4'b1000), OR (4'b1001), XOR (4'b1010) and NOR (4'b1011).
- R6: With `use_imm`=1, ADD, SUB and SLT sign-extend `imm_raw` from bit 15. ADDU, SUBU and SLTU zero-extend it. The unsigned variants are the arithmetic opcodes with bit 0 set.
- R7: SLT (4'b0100) returns 32'h1 when `rs_val` is less than the second operand as signed numbers, and 32'h0 otherwise.
- R8: SLTU (4'b0101) returns 32'h1 when `rs_val` is less than the second operand as unsigned numbers, and 32'h0 otherwise.
- R9: AND, OR, XOR and NOR return the bitwise function of the two operands, with NOR = ~(a|b). They never trap.
- R10: Any opcode not listed above gives `result`=0, `wr_en`=0 and `ovf_trap`=0.
- R11: With `use_imm`=0, the second operand is `rt_val`, and `imm_raw` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_code | input | 4 | Operation select, with encodings as listed in the requirements |
| use_imm | input | 1 | 1 selects the extended immediate as the second operand; 0 selects `rt_val` |
| rs_val | input | 32 | First register operand |
| rt_val | input | 32 | Second register operand |
| imm_raw | input | 16 | Raw immediate field from the instruction |
| result | output | 32 | Operation result |
| wr_en | output | 1 | Destination register write is allowed |
| ovf_trap | output | 1 | Signed overflow exception strobe |

## Verification
The bench builds the block with its default widths: a 32-bit datapath and a 16-bit immediate. At these widths the two overflow boundaries, 0x7FFFFFFF+1 and 0x80000000-1, can be written literally. The sign bit of the immediate, bit 15, sits strictly inside the operand, so sign-fill and zero-fill give visibly different upper halves. These widths also let the reference model detect overflow from a 33-bit widened sum, which does not rely on the sign-comparison rule the RTL uses.

// File: rtl/rv_alu_pkg.sv
package rv_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'b0000,
    OP_ADDU = 4'b0001,
    OP_SUB  = 4'b0010,
    OP_SUBU = 4'b0011,
    OP_SLT  = 4'b0100,
    OP_SLTU = 4'b0101,
    OP_AND  = 4'b1000,
    OP_OR   = 4'b1001,
    OP_XOR  = 4'b1010,
    OP_NOR  = 4'b1011
  } alu_op_e;

  // Signed overflow from the sign bits of both adder inputs and of the sum.
  function automatic logic add_ovf(input logic a_msb, input logic b_msb, input logic r_msb);
    return (a_msb == b_msb) && (r_msb != a_msb);
  endfunction

  // Signed less-than, recovered from the subtractor's sign bit and overflow.
  function automatic logic slt_signed(input logic diff_msb, input logic ovf);
    return diff_msb ^ ovf;
  endfunction

  // Unsigned less-than: a - b borrows when the carry out of a + ~b + 1 is low.
  function automatic logic slt_unsigned(input logic carry_out);
    return ~carry_out;
  endfunction

  function automatic logic is_logic_op(input alu_op_e op);
    return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR) || (op == OP_NOR);
  endfunction

  function automatic logic uses_subtract(input alu_op_e op);
    return (op == OP_SUB) || (op == OP_SUBU) || (op == OP_SLT) || (op == OP_SLTU);
  endfunction

  function automatic logic may_trap(input alu_op_e op);
    return (op == OP_ADD) || (op == OP_SUB);
  endfunction

  function automatic logic is_known_op(input alu_op_e op);
    return (op == OP_ADD) || (op == OP_ADDU) || (op == OP_SUB) || (op == OP_SUBU) ||
           (op == OP_SLT) || (op == OP_SLTU) || is_logic_op(op);
  endfunction

endpackage

// File: rtl/rv_alu_opnd_sel.sv
module rv_alu_opnd_sel
  import rv_alu_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int IMMW = 16
) (
  input  alu_op_e          op,
  input  logic             use_imm,
  input  logic [XLEN-1:0]  rt_val,
  input  logic [IMMW-1:0]  imm_raw,
  output logic             zero_fill,
  output logic [XLEN-1:0]  opnd_b
);
  localparam int PADW = XLEN - IMMW;

  logic [XLEN-1:0] imm_ext;

  // Logic ops and unsigned variants (opcode bit 0 set among arithmetic) zero-fill.
  assign zero_fill = is_logic_op(op) || op[0];

  generate
    if (PADW > 0) begin : g_pad
      assign imm_ext = zero_fill ? {{PADW{1'b0}}, imm_raw}
                                 : {{PADW{imm_raw[IMMW-1]}}, imm_raw};
    end else begin : g_nopad
      assign imm_ext = imm_raw[XLEN-1:0];
    end
  endgenerate

  assign opnd_b = use_imm ? imm_ext : rt_val;
endmodule

// File: rtl/rv_alu_addsub.sv
module rv_alu_addsub
  import rv_alu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic            sub,
  output logic [XLEN-1:0] sum,
  output logic            carry_out,
  output logic            ovf_raw
);
  logic [XLEN-1:0] b_eff;

  assign b_eff = sub ? ~b : b;
  assign {carry_out, sum} = {1'b0, a} + {1'b0, b_eff} + {{XLEN{1'b0}}, sub};
  assign ovf_raw = add_ovf(a[XLEN-1], b_eff[XLEN-1], sum[XLEN-1]);
endmodule

// File: rtl/rv_alu_logic.sv
module rv_alu_logic #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic [1:0]      fn,
  output logic [XLEN-1:0] res
);
  always_comb begin
    unique case (fn)
      2'd0:    res = a & b;
      2'd1:    res = a | b;
      2'd2:    res = a ^ b;
      default: res = ~(a | b);
    endcase
  end
endmodule

// File: rtl/rv_alu.sv
module rv_alu
  import rv_alu_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int IMMW = 16
) (
  input  logic [3:0]      op_code,
  input  logic            use_imm,
  input  logic [XLEN-1:0] rs_val,
  input  logic [XLEN-1:0] rt_val,
  input  logic [IMMW-1:0] imm_raw,
  output logic [XLEN-1:0] result,
  output logic            wr_en,
  output logic            ovf_trap
);
  alu_op_e         op;
  logic            zero_fill;
  logic [XLEN-1:0] opnd_b;
  logic [XLEN-1:0] sum;
  logic            carry_out;
  logic            ovf_raw;
  logic [XLEN-1:0] logic_res;
  logic            lt_flag;

  assign op = alu_op_e'(op_code);

  rv_alu_opnd_sel #(.XLEN(XLEN), .IMMW(IMMW)) u_sel (
    .op(op), .use_imm(use_imm), .rt_val(rt_val), .imm_raw(imm_raw),
    .zero_fill(zero_fill), .opnd_b(opnd_b)
  );

  rv_alu_addsub #(.XLEN(XLEN)) u_addsub (
    .a(rs_val), .b(opnd_b), .sub(uses_subtract(op)),
    .sum(sum), .carry_out(carry_out), .ovf_raw(ovf_raw)
  );

  rv_alu_logic #(.XLEN(XLEN)) u_logic (
    .a(rs_val), .b(opnd_b), .fn(op_code[1:0]), .res(logic_res)
  );

  assign lt_flag = (op == OP_SLTU) ? slt_unsigned(carry_out)
                                   : slt_signed(sum[XLEN-1], ovf_raw);

  always_comb begin
    result = '0;
    case (op)
      OP_ADD, OP_ADDU, OP_SUB, OP_SUBU: result = sum;
      OP_SLT, OP_SLTU:                  result = {{(XLEN-1){1'b0}}, lt_flag};
      OP_AND, OP_OR, OP_XOR, OP_NOR:    result = logic_res;
      default:                          result = '0;
    endcase
  end

  assign ovf_trap = may_trap(op) && ovf_raw;
  assign wr_en    = is_known_op(op) && !ovf_trap;
endmodule

// File: rtl/rv_alu_chk.sv
module rv_alu_chk
  import rv_alu_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int IMMW = 16
) (
  input logic [3:0]      op_code,
  input logic            use_imm,
  input logic [XLEN-1:0] rt_val,
  input logic [IMMW-1:0] imm_raw,
  input logic            zero_fill,
  input logic [XLEN-1:0] opnd_b,
  input logic [XLEN-1:0] result,
  input logic            wr_en,
  input logic            ovf_trap
);
  localparam int PADW = XLEN - IMMW;

  alu_op_e op;
  assign op = alu_op_e'(op_code);

  always_comb begin
    if (ovf_trap) begin
      a_r4_no_write_on_trap: assert (!wr_en);
      a_r2_trap_only_signed: assert (op == OP_ADD || op == OP_SUB);
    end
    if (op == OP_ADDU || op == OP_SUBU) begin
      a_r3_unsigned_silent: assert (!ovf_trap);
    end
    if (use_imm && (op == OP_AND || op == OP_OR || op == OP_XOR || op == OP_NOR)) begin
      a_r5_logic_zero_fill: assert (opnd_b[XLEN-1:IMMW] == '0 && zero_fill);
    end
    if (use_imm && (op == OP_ADD || op == OP_SUB || op == OP_SLT)) begin
      a_r6_signed_fill: assert (opnd_b[XLEN-1:IMMW] == {PADW{imm_raw[IMMW-1]}});
    end
    if (op == OP_SLT || op == OP_SLTU) begin
      a_r7_compare_boolean: assert (result[XLEN-1:1] == '0 && !ovf_trap);
    end
    if (!use_imm) begin
      a_r11_register_path: assert (opnd_b == rt_val);
    end
  end
endmodule

bind rv_alu rv_alu_chk #(.XLEN(XLEN), .IMMW(IMMW)) u_chk (
  .op_code(op_code), .use_imm(use_imm), .rt_val(rt_val), .imm_raw(imm_raw),
  .zero_fill(zero_fill), .opnd_b(opnd_b), .result(result),
  .wr_en(wr_en), .ovf_trap(ovf_trap)
);

// File: tb/tb_rv_alu.sv
module tb_rv_alu;
  localparam int XLEN = 32;
  localparam int IMMW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [3:0]      op_code = 4'd0;
  logic            use_imm = 1'b0;
  logic [XLEN-1:0] rs_val = '0;
  logic [XLEN-1:0] rt_val = '0;
  logic [IMMW-1:0] imm_raw = '0;
  logic [XLEN-1:0] result;
  logic            wr_en;
  logic            ovf_trap;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  rv_alu #(.XLEN(XLEN), .IMMW(IMMW)) dut (
    .op_code(op_code), .use_imm(use_imm), .rs_val(rs_val), .rt_val(rt_val),
    .imm_raw(imm_raw), .result(result), .wr_en(wr_en), .ovf_trap(ovf_trap)
  );

  // Independent reference: 33-bit widened arithmetic for overflow detection.
  task automatic model(input logic [3:0] op, input logic ui, input logic [31:0] a,
                       input logic [31:0] rt, input logic [15:0] imm,
                       output logic [31:0] er, output logic ew, output logic et);
    logic [31:0] b;
    logic [32:0] w;
    logic zfill;
    zfill = op[3] || op[0];
    b = !ui ? rt : (zfill ? {16'h0, imm} : {{16{imm[15]}}, imm});
    er = 32'h0; ew = 1'b1; et = 1'b0;
    case (op)
      4'b0000: begin w = {a[31], a} + {b[31], b}; er = a + b; et = (w[32] != w[31]); end
      4'b0001: er = a + b;
      4'b0010: begin w = {a[31], a} - {b[31], b}; er = a - b; et = (w[32] != w[31]); end
      4'b0011: er = a - b;
      4'b0100: er = ($signed(a) < $signed(b)) ? 32'h1 : 32'h0;
      4'b0101: er = (a < b) ? 32'h1 : 32'h0;
      4'b1000: er = a & b;
      4'b1001: er = a | b;
      4'b1010: er = a ^ b;
      4'b1011: er = ~(a | b);
      default: begin er = 32'h0; ew = 1'b0; end
    endcase
    if (et) ew = 1'b0;
  endtask

  task automatic apply(input logic [3:0] op, input logic ui, input logic [31:0] a,
                       input logic [31:0] rt, input logic [15:0] imm, input string rq);
    logic [31:0] er;
    logic ew, et;
    @(negedge clk);
    op_code = op; use_imm = ui; rs_val = a; rt_val = rt; imm_raw = imm;
    #2;
    model(op, ui, a, rt, imm, er, ew, et);
    n_checks++;
    if (result !== er || wr_en !== ew || ovf_trap !== et) begin
      n_fail++;
      $display("FAIL %s op=%b ui=%b a=%h rt=%h imm=%h : got res=%h we=%b trap=%b exp res=%h we=%b trap=%b",
               rq, op, ui, a, rt, imm, result, wr_en, ovf_trap, er, ew, et);
    end
  endtask

  task automatic t_reset_state();
    // R1: all-zero inputs during reset give an ADD of zero: result 0, write allowed
    n_checks++;
    if (result !== 32'h0 || wr_en !== 1'b1 || ovf_trap !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset state: got res=%h we=%b trap=%b exp res=0 we=1 trap=0",
               result, wr_en, ovf_trap);
    end
  endtask

  task automatic t_signed_overflow();
    apply(4'b0000, 1'b0, 32'h7FFFFFFF, 32'h1, 16'h0, "R2 add max+1");
    apply(4'b0010, 1'b0, 32'h80000000, 32'h1, 16'h0, "R2 sub min-1");
    apply(4'b0000, 1'b0, 32'h80000000, 32'h80000000, 16'h0, "R2 add min+min");
    apply(4'b0010, 1'b0, 32'h7FFFFFFF, 32'hFFFFFFFF, 16'h0, "R2 sub max-(-1)");
    apply(4'b0000, 1'b0, 32'h7FFFFFFE, 32'h1, 16'h0, "R2 add no overflow");
    apply(4'b0000, 1'b1, 32'h7FFFFFFF, 32'h0, 16'h0001, "R4 add imm overflow");
  endtask

  task automatic t_unsigned_wrap();
    apply(4'b0001, 1'b0, 32'h7FFFFFFF, 32'h1, 16'h0, "R3 addu max+1");
    apply(4'b0011, 1'b0, 32'h80000000, 32'h1, 16'h0, "R3 subu min-1");
    apply(4'b0001, 1'b0, 32'hFFFFFFFF, 32'h2, 16'h0, "R1 addu wrap");
    apply(4'b0011, 1'b0, 32'h0, 32'h1, 16'h0, "R1 subu borrow");
  endtask

  task automatic t_imm_extension();
    apply(4'b0000, 1'b1, 32'h10, 32'h0, 16'hFFFF, "R6 add sext -1");
    apply(4'b0001, 1'b1, 32'h10, 32'h0, 16'hFFFF, "R6 addu zext");
    apply(4'b0010, 1'b1, 32'h0, 32'h0, 16'h8000, "R6 sub sext");
    apply(4'b0011, 1'b1, 32'h0, 32'h0, 16'h8000, "R6 subu zext");
    apply(4'b0100, 1'b1, 32'h0, 32'h0, 16'hFFFF, "R6 slt sext");
    apply(4'b0101, 1'b1, 32'h0, 32'h0, 16'hFFFF, "R6 sltu zext");
    apply(4'b1001, 1'b1, 32'h0, 32'h0, 16'h8001, "R5 or imm zext");
    apply(4'b1000, 1'b1, 32'hFFFFFFFF, 32'h0, 16'hF0F0, "R5 and imm zext");
    apply(4'b1010, 1'b1, 32'hFFFF0000, 32'h0, 16'hFFFF, "R5 xor imm zext");
    apply(4'b1011, 1'b1, 32'h0, 32'h0, 16'h8000, "R5 nor imm zext");
  endtask

  task automatic t_compare();
    apply(4'b0100, 1'b0, 32'hFFFFFFFF, 32'h1, 16'h0, "R7 slt -1<1");
    apply(4'b0100, 1'b0, 32'h80000000, 32'h7FFFFFFF, 16'h0, "R7 slt min<max");
    apply(4'b0100, 1'b0, 32'h7FFFFFFF, 32'h80000000, 16'h0, "R7 slt max<min false");
    apply(4'b0100, 1'b0, 32'h5, 32'h5, 16'h0, "R7 slt equal");
    apply(4'b0101, 1'b0, 32'h1, 32'hFFFFFFFF, 16'h0, "R8 sltu 1<max");
    apply(4'b0101, 1'b0, 32'hFFFFFFFF, 32'h1, 16'h0, "R8 sltu false");
    apply(4'b0101, 1'b0, 32'h7, 32'h7, 16'h0, "R8 sltu equal");
  endtask

  task automatic t_logic();
    apply(4'b1000, 1'b0, 32'hF0F0A5A5, 32'hFF00FF00, 16'h0, "R9 and");
    apply(4'b1001, 1'b0, 32'hF0F0A5A5, 32'h0F0F0000, 16'h0, "R9 or");
    apply(4'b1010, 1'b0, 32'hFFFFFFFF, 32'h12345678, 16'h0, "R9 xor");
    apply(4'b1011, 1'b0, 32'h80000000, 32'h00000001, 16'h0, "R9 nor");
  endtask

  task automatic t_reserved();
    for (int k = 6; k < 16; k++) begin
      if (k != 8 && k != 9 && k != 10 && k != 11)
        apply(4'(k), 1'b0, 32'hDEADBEEF, 32'h7FFFFFFF, 16'h1234, "R10 reserved op");
    end
  endtask

  task automatic t_imm_ignored();
    apply(4'b0000, 1'b0, 32'h100, 32'h23, 16'h0000, "R11 imm ignored a");
    apply(4'b0000, 1'b0, 32'h100, 32'h23, 16'hFFFF, "R11 imm ignored b");
    apply(4'b1001, 1'b0, 32'h0, 32'h0, 16'hABCD, "R11 imm ignored logic");
  endtask

  task automatic t_random();
    logic [3:0] ops [10] = '{4'b0000, 4'b0001, 4'b0010, 4'b0011, 4'b0100,
                             4'b0101, 4'b1000, 4'b1001, 4'b1010, 4'b1011};
    for (int i = 0; i < 2000; i++) begin
      apply(ops[$urandom_range(9)], 1'($urandom), $urandom, $urandom, 16'($urandom),
            "R1 random vs model");
    end
  endtask

  initial begin
    void'($urandom(32'h1F2E3D4C));
    repeat (3) @(posedge clk);
    @(negedge clk); #2;
    t_reset_state();
    rst_n = 1'b1;
    t_signed_overflow();
    t_unsigned_wrap();
    t_imm_extension();
    t_compare();
    t_logic();
    t_reserved();
    t_imm_ignored();
    t_random();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule